// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the eight-bit status byte of a serial memory and rules on every write that reaches the memory. The command decoder that sits in front of it hands over one-cycle strobes for three commands: arm writes, disarm writes, and load the status byte together with its data byte. The level of the write-protect pin arrives as a plain input. For each memory byte write, the block receives a request and the byte's target address. In the same cycle it answers with either a grant or a deny.

The current status byte is always driven out, ready for a read-out path. The byte holds a write-enable latch, two zone bits that fence off the top quarter, the top half or the whole array, and a lock bit. When the lock bit is set, status loads also require the pin to be high. Four further bits are free storage that the block only holds and returns. The stored byte is modelled as flops with a reset value.

A denied memory write only raises the deny output. Advancing the address is left to the caller, which moves on to the next byte whether or not the write was granted.

Top module: `status_write_guard`

## Requirements
- R1: After reset the status byte reads 00h, and a memory write request is denied.
- R2: The status byte layout is bit 7 = lock, bits 3:2 = zone, bit 1 = write-enable latch. Bits 6, 5, 4 and 0 are stored by a granted status load and read back, and they change no grant or deny decision.
- R3: With a 15-bit address, zone 00 protects no address, 01 protects 6000h and above, 10 protects 4000h and above, and 11 protects every address. A memory write request is granted only when the latch is 1 and the address lies outside the protected zone.
- R4: While the latch is 0, every memory write request and every status load is denied, and a denied status load leaves the status byte unchanged.
- R5: While the latch is 1 and the lock bit is 0, a status load is granted at either pin level.
- R6: While the latch is 1 and the lock bit is 1, a status load is granted only if the pin is high. A denied load leaves the status byte unchanged.
- R7: The arm-writes strobe sets the latch and the disarm-writes strobe clears it. The new value is visible one clock after the strobe.
- R8: A granted status load never changes the latch, whatever bit 1 of the data byte holds.
- R9: The grant and deny outputs answer in the same cycle as the request. Exactly one of them is high while a request is present, and neither is high without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdArm | input | 1 | Arm-writes strobe, one cycle |
| cmdDisarm | input | 1 | Disarm-writes strobe, one cycle |
| cmdStatLoad | input | 1 | Status-load strobe, one cycle |
| statLoadData | input | 8 | Data byte carried with the status load |
| wpPin | input | 1 | Write-protect pin level, high = permit |
| memWrReq | input | 1 | Memory byte write request |
| memWrAddr | input | ADDR_W (15) | Target byte address of the request |
| memWrGrant | output | 1 | Memory write allowed |
| memWrDeny | output | 1 | Memory write refused |
| statLoadGrant | output | 1 | Status load allowed this cycle |
| statLoadDeny | output | 1 | Status load refused this cycle |
| statusByte | output | 8 | Current status byte |

## Verification
The assertions assume the decoder raises at most one of the three command strobes in any cycle, because only one command can run per chip-select period. The bench honours this by issuing each command through a task that raises a single strobe for exactly one cycle.

The assertions also assume the write-protect pin does not change while a status load strobe is high. The bench sets the pin one cycle before the strobe and holds it there.

The latch-related assertions take the latch value from the register's previous cycle. They therefore depend on the bench applying no strobe in the cycle that reset is released, and the bench waits several clocks after reset before issuing any command.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int STAT_W   = 8;
  localparam int LOCK_BIT = 7;
  localparam int ZONE_HI  = 3;
  localparam int ZONE_LO  = 2;
  localparam int WEL_BIT  = 1;

  typedef enum logic [1:0] {
    ZONE_NONE    = 2'b00,
    ZONE_QUARTER = 2'b01,
    ZONE_HALF    = 2'b10,
    ZONE_ALL     = 2'b11
  } zone_e;

  typedef struct packed {
    logic ldStat;
    logic setWel;
    logic clrWel;
  } ctrlStrobe_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdArm,
  input  logic        cmdDisarm,
  input  logic        cmdStatLoad,
  input  logic        wpPin,
  input  logic        welQ,
  input  logic        lockQ,
  output ctrlStrobe_t strb,
  output logic        statLoadGrant,
  output logic        statLoadDeny
);
  logic loadPermitted;

  // A status load needs the latch, and the pin only matters once locked.
  always_comb begin
    loadPermitted = welQ && (!lockQ || wpPin);
    statLoadGrant = cmdStatLoad && loadPermitted;
    statLoadDeny  = cmdStatLoad && !loadPermitted;
    strb.ldStat   = statLoadGrant;
    strb.setWel   = cmdArm && !cmdDisarm;
    strb.clrWel   = cmdDisarm;
  end

  // Input assumption: one command per cycle.
  assert_single_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmdArm, cmdDisarm, cmdStatLoad}));

  assert_load_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStatLoad && !welQ) |-> (statLoadDeny && !strb.ldStat));

  assert_unlocked_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStatLoad && welQ && !lockQ) |-> statLoadGrant);

  assert_locked_needs_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (statLoadGrant && lockQ) |-> wpPin);

  assert_load_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdStatLoad |-> (statLoadGrant ^ statLoadDeny));
endmodule

// File: rtl/wpg_regs.sv
module wpg_regs
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 15
)(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [STAT_W-1:0] statLoadData,
  input  logic              memWrReq,
  input  logic [ADDR_W-1:0] memWrAddr,
  output logic [STAT_W-1:0] statusQ,
  output logic              memWrGrant,
  output logic              memWrDeny
);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);

  logic  welQ;
  logic  lockQ;
  zone_e zoneQ;
  logic  [3:0] userQ;
  logic  inFence;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      welQ  <= 1'b0;
      lockQ <= 1'b0;
      zoneQ <= ZONE_NONE;
      userQ <= '0;
    end else begin
      if (strb.clrWel)      welQ <= 1'b0;
      else if (strb.setWel) welQ <= 1'b1;
      if (strb.ldStat) begin
        lockQ <= statLoadData[LOCK_BIT];
        zoneQ <= zone_e'(statLoadData[ZONE_HI:ZONE_LO]);
        userQ <= {statLoadData[6:4], statLoadData[0]};
      end
    end
  end

  always_comb begin
    unique case (zoneQ)
      ZONE_NONE:    inFence = 1'b0;
      ZONE_QUARTER: inFence = (memWrAddr >= QTR_BASE);
      ZONE_HALF:    inFence = (memWrAddr >= HALF_BASE);
      default:      inFence = 1'b1;
    endcase
    memWrGrant = memWrReq && welQ && !inFence;
    memWrDeny  = memWrReq && !(welQ && !inFence);
    statusQ    = {lockQ, userQ[3:1], zoneQ, welQ, userQ[0]};
  end

  assert_mem_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !statusQ[WEL_BIT] |-> !memWrGrant);

  assert_all_fenced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrReq && statusQ[ZONE_HI:ZONE_LO] == 2'b11) |-> memWrDeny);

  assert_top_quarter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (memWrReq && statusQ[ZONE_HI:ZONE_LO] != 2'b00 &&
     memWrAddr[ADDR_W-1:ADDR_W-2] == 2'b11) |-> !memWrGrant);

  assert_arm_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setWel |=> statusQ[WEL_BIT]);

  assert_disarm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrWel |=> !statusQ[WEL_BIT]);

  assert_load_keeps_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ldStat && !strb.setWel && !strb.clrWel && !statLoadData[WEL_BIT])
      |=> statusQ[WEL_BIT]);

  assert_mem_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    memWrReq |-> (memWrGrant ^ memWrDeny));

  assert_mem_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !memWrReq |-> (!memWrGrant && !memWrDeny));
endmodule

// File: rtl/status_write_guard.sv
module status_write_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 15
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdArm,
  input  logic              cmdDisarm,
  input  logic              cmdStatLoad,
  input  logic [STAT_W-1:0] statLoadData,
  input  logic              wpPin,
  input  logic              memWrReq,
  input  logic [ADDR_W-1:0] memWrAddr,
  output logic              memWrGrant,
  output logic              memWrDeny,
  output logic              statLoadGrant,
  output logic              statLoadDeny,
  output logic [STAT_W-1:0] statusByte
);
  ctrlStrobe_t strb;
  logic [STAT_W-1:0] statusQ;

  wpg_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmdArm        (cmdArm),
    .cmdDisarm     (cmdDisarm),
    .cmdStatLoad   (cmdStatLoad),
    .wpPin         (wpPin),
    .welQ          (statusQ[WEL_BIT]),
    .lockQ         (statusQ[LOCK_BIT]),
    .strb          (strb),
    .statLoadGrant (statLoadGrant),
    .statLoadDeny  (statLoadDeny)
  );

  wpg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .statLoadData (statLoadData),
    .memWrReq     (memWrReq),
    .memWrAddr    (memWrAddr),
    .statusQ      (statusQ),
    .memWrGrant   (memWrGrant),
    .memWrDeny    (memWrDeny)
  );

  assign statusByte = statusQ;
endmodule

// File: tb/status_write_guard_tb.sv
`timescale 1ns/1ps
module status_write_guard_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdArm = 0, cmdDisarm = 0, cmdStatLoad = 0, wpPin = 0, memWrReq = 0;
  logic [7:0] statLoadData = '0;
  logic [14:0] memWrAddr = '0;
  logic memWrGrant, memWrDeny, statLoadGrant, statLoadDeny;
  logic [7:0] statusByte;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  status_write_guard u_dut (
    .clk(clk), .rst_n(rst_n), .cmdArm(cmdArm), .cmdDisarm(cmdDisarm),
    .cmdStatLoad(cmdStatLoad), .statLoadData(statLoadData), .wpPin(wpPin),
    .memWrReq(memWrReq), .memWrAddr(memWrAddr), .memWrGrant(memWrGrant),
    .memWrDeny(memWrDeny), .statLoadGrant(statLoadGrant),
    .statLoadDeny(statLoadDeny), .statusByte(statusByte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic arm();
    @(negedge clk); cmdArm = 1;
    @(negedge clk); cmdArm = 0;
  endtask

  task automatic disarm();
    @(negedge clk); cmdDisarm = 1;
    @(negedge clk); cmdDisarm = 0;
  endtask

  // Sets the pin one cycle ahead, loads, returns the grant seen in the strobe cycle.
  task automatic load(input logic [7:0] d, input logic pin, output logic g, output logic dn);
    @(negedge clk); wpPin = pin;
    @(negedge clk); cmdStatLoad = 1; statLoadData = d;
    #1; g = statLoadGrant; dn = statLoadDeny;
    @(negedge clk); cmdStatLoad = 0;
  endtask

  task automatic probe(input logic [14:0] a, output logic g, output logic dn);
    @(negedge clk); memWrReq = 1; memWrAddr = a;
    #1; g = memWrGrant; dn = memWrDeny;
    @(negedge clk); memWrReq = 0;
  endtask

  task automatic t_reset();
    logic g, dn;
    chk("R1 status after reset", statusByte, 8'h00);
    probe(15'h0000, g, dn);
    chk("R1 reset write deny", {g, dn}, 2'b01);
    #1; chk("R9 idle no grant/deny", {memWrGrant, memWrDeny}, 2'b00);
  endtask

  task automatic t_latch();
    logic g, dn;
    arm();
    chk("R7 arm sets latch", statusByte, 8'h02);
    disarm();
    chk("R7 disarm clears latch", statusByte, 8'h00);
    load(8'hFD, 1'b1, g, dn);
    chk("R4 load deny without latch", {g, dn}, 2'b01);
    chk("R4 status unchanged", statusByte, 8'h00);
  endtask

  task automatic t_unlocked();
    logic g, dn;
    arm();
    load(8'h71, 1'b0, g, dn);
    chk("R5 unlocked load pin low", {g, dn}, 2'b01 << 1);
    chk("R8 latch kept, R2 user bits", statusByte, 8'h73);
    load(8'h00, 1'b1, g, dn);
    chk("R5 unlocked load pin high", {g, dn}, 2'b10);
    chk("R8 latch kept after zero load", statusByte, 8'h02);
  endtask

  function automatic logic fenced(input logic [1:0] z, input logic [14:0] a);
    case (z)
      2'b00: return 1'b0;
      2'b01: return a >= 15'h6000;
      2'b10: return a >= 15'h4000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic t_zones();
    logic g, dn;
    logic [14:0] addrs [6] = '{15'h0000, 15'h3FFF, 15'h4000, 15'h5FFF, 15'h6000, 15'h7FFF};
    for (int u = 0; u < 2; u++) begin
      for (int z = 0; z < 4; z++) begin
        logic [7:0] d;
        d = (u != 0 ? 8'h71 : 8'h00) | 8'(z << 2);
        load(d, 1'b0, g, dn);
        chk("R2 zone load readback", statusByte, d | 8'h02);
        for (int i = 0; i < 6; i++) begin
          probe(addrs[i], g, dn);
          chk(u != 0 ? "R2 user bits no effect R3" : "R3 zone decode",
              {g, dn}, fenced(2'(z), addrs[i]) ? 2'b01 : 2'b10);
        end
      end
    end
    disarm();
    probe(15'h0000, g, dn);
    chk("R4 mem deny latch low", {g, dn}, 2'b01);
  endtask

  task automatic t_lock();
    logic g, dn;
    arm();
    load(8'h80, 1'b0, g, dn);
    chk("R5 set lock", statusByte, 8'h82);
    load(8'h0C, 1'b0, g, dn);
    chk("R6 locked pin low deny", {g, dn}, 2'b01);
    chk("R6 status unchanged", statusByte, 8'h82);
    load(8'h0C, 1'b1, g, dn);
    chk("R6 locked pin high grant", {g, dn}, 2'b10);
    chk("R6 status loaded", statusByte, 8'h0E);
    disarm();
    load(8'h00, 1'b1, g, dn);
    chk("R4 deny after disarm", {g, dn}, 2'b01);
    chk("R4 status held", statusByte, 8'h0C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latch();
    t_unlocked();
    t_zones();
    t_lock();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule